// File: doc/BRIEF.md
# RTC Tick Prescaler and Interrupt Gatherer

This block turns a slow oscillator, seen as a one-cycle enable pulse on the system clock, into a family of periodic ticks. These are a 512 Hz base tick and its halvings down to 2 Hz and 1 Hz. The oscillator may run at 32768 Hz, 32000 Hz or 38400 Hz. A fractional accumulator adds 512 per oscillator pulse and wraps at the selected rate, so the two rates that are not powers of two still give an exact long-term 512 Hz. The 1 Hz tick leaves the block to advance an external time counter.

Every tick rate and two outside events, alarm and stopwatch, set sticky bits in a status register. Software clears those bits by writing ones to them. An enable mask selects which set bits raise the single interrupt line. A simple register bus reaches the control, status and mask registers. Writes take effect on the clock edge, and reads are combinational from the address.

Top module: `rtc_tick_irq`

## Requirements
- R1: The control register at address 0x10 holds the enable in bit 7 and the rate select in bits 6:5. Select value 0 means 32768 Hz, 1 means 32000 Hz and 2 means 38400 Hz, and value 3 behaves like 0. A read returns bits 7:5 as written and zero in all other bits.
- R2: While the block is enabled, the n-th oscillator pulse after a restart gives a base 512 Hz tick exactly when floor(512*n/rate) increases. The first base tick is therefore on pulse ceil(rate/512), which is 64, 63 or 75.
- R3: `tick_1hz` is high for one cycle, on the oscillator pulse whose index since the restart is a multiple of the selected rate.
- R4: A tick of 2^m Hz (m = 0..9) is the base tick whose running count is a multiple of 512/2^m. Status bit 4 records 1 Hz and bit 7 records 2 Hz. Bits 8 to 15 record 4, 8, 16, 32, 64, 128, 256 and 512 Hz, in that order.
- R5: A stopwatch event sets status bit 0 and an alarm event sets status bit 2, whether or not the bits are enabled and whether or not the block is enabled. The status register at 0x14 reads zero in bits 1, 3, 5 and 6.
- R6: Writing the status register clears each bit written as 1 and leaves each bit written as 0. Writing 0xFFFF clears every bit, and a status bit never clears without a write.
- R7: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R8: The enable mask at 0x18 is readable and writable, with one bit for each status position. Unimplemented positions read zero, so writing 0xFFFF reads back as 0xFF95.
- R9: `irq` is high in exactly the cycles in which some status bit and its mask bit are both 1. It rises the cycle after the status bit sets.
- R10: While the enable bit is 0, the accumulator and the tick counter are held at zero and oscillator pulses produce no ticks. Any write to the control register restarts counting from zero.
- R11: After reset, all three registers read zero, and `irq` and `tick_1hz` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_en | input | 1 | One-cycle pulse per oscillator period |
| stopwatch_evt | input | 1 | Stopwatch event pulse |
| alarm_evt | input | 1 | Alarm event pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| tick_1hz | output | 1 | One-cycle pulse at 1 Hz |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the wrap of the whole divider chain, where every tick rate fires on the same base tick. This happens only after a full second of oscillator pulses, so the stimulus drives one pulse on every clock for 32768 and 38400 pulses. For the 32000 Hz rate it stops exactly at and just before the 2 Hz boundary. A scoreboard keeps the expected pulse index of each 1 Hz tick, and the status register is read at the pulse counts where the accumulator's fractional wrap should place the first base tick. The case where an event and a clear hit the same bit is reached by driving an alarm pulse in the cycle of a status write.

// File: rtl/rtc_tick_irq.sv
module rtc_tick_irq #(
  parameter int RATE0 = 32768,
  parameter int RATE1 = 32000,
  parameter int RATE2 = 38400,
  parameter logic [7:0] A_CTRL = 8'h10,
  parameter logic [7:0] A_STAT = 8'h14,
  parameter logic [7:0] A_MASK = 8'h18
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        osc_en,
  input  logic        stopwatch_evt,
  input  logic        alarm_evt,
  input  logic        wr_en,
  input  logic [7:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        tick_1hz,
  output logic        irq
);
  localparam int BASE_HZ = 512;
  localparam int DIV_W   = $clog2(BASE_HZ);
  localparam int ACC_W   = $clog2(RATE2 + BASE_HZ) + 1;
  localparam logic [15:0] IMPL = 16'hFF95;

  logic             en_q;
  logic [1:0]       sel_q;
  logic [ACC_W-1:0] acc_q, acc_sum, rate_w;
  logic [DIV_W-1:0] div_q;
  logic [15:0]      stat_q, mask_q, ev_set;
  logic [DIV_W:0]   tick;
  logic             base_tick;

  wire wr_ctrl = wr_en && addr == A_CTRL;
  wire wr_stat = wr_en && addr == A_STAT;
  wire wr_mask = wr_en && addr == A_MASK;

  always_comb begin
    case (sel_q)
      2'd1:    rate_w = ACC_W'(RATE1);
      2'd2:    rate_w = ACC_W'(RATE2);
      default: rate_w = ACC_W'(RATE0);
    endcase
  end

  assign acc_sum   = acc_q + ACC_W'(BASE_HZ);
  assign base_tick = en_q && osc_en && acc_sum >= rate_w;

  assign tick[0] = base_tick;
  for (genvar k = 1; k <= DIV_W; k++) begin : g_tick
    assign tick[k] = base_tick && (&div_q[k-1:0]);
  end

  assign tick_1hz = tick[DIV_W];

  always_comb begin
    ev_set    = '0;
    ev_set[0] = stopwatch_evt;
    ev_set[2] = alarm_evt;
    ev_set[4] = tick[DIV_W];
    ev_set[7] = tick[DIV_W-1];
    for (int j = 0; j < 8; j++) ev_set[8+j] = tick[7-j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else if (wr_ctrl) begin
      en_q  <= wdata[7];
      sel_q <= wdata[6:5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      div_q <= '0;
    end else if (!en_q || wr_ctrl) begin
      acc_q <= '0;
      div_q <= '0;
    end else if (osc_en) begin
      acc_q <= base_tick ? acc_sum - rate_w : acc_sum;
      if (base_tick) div_q <= div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= ((stat_q & ~(wr_stat ? wdata : 16'h0)) | ev_set) & IMPL;
      if (wr_mask) mask_q <= wdata & IMPL;
    end
  end

  assign irq = |(stat_q & mask_q);

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {8'h0, en_q, sel_q, 5'h0};
      A_STAT:  rdata = stat_q;
      A_MASK:  rdata = mask_q;
      default: rdata = '0;
    endcase
  end

  p_acc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < rate_w);
  p_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (acc_q == '0 && div_q == '0));
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> stat_q[2]);
  p_tick_recorded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz |=> (stat_q[4] && stat_q[7] && stat_q[15]));
  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_q != '0 && mask_q != '0));
endmodule

// File: tb/test_rtc_tick_irq.sv
module test_rtc_tick_irq;
  localparam logic [7:0] A_CTRL = 8'h10;
  localparam logic [7:0] A_STAT = 8'h14;
  localparam logic [7:0] A_MASK = 8'h18;

  logic clk = 0, rst_n = 0, osc_en = 0, stopwatch_evt = 0, alarm_evt = 0, wr_en = 0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic tick_1hz, irq;

  rtc_tick_irq i_rtc_tick_irq (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stopwatch_evt(stopwatch_evt),
    .alarm_evt(alarm_evt), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tick_1hz(tick_1hz), .irq(irq));

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0, osc_count = 0;
  int exp_q[$];
  logic [15:0] d;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #5;
    if (osc_en) begin
      osc_count++;
      if (tick_1hz) begin : pop
        int e;
        if (exp_q.size() == 0) check(0, "R3 unexpected 1 Hz tick", osc_count, 0);
        else begin
          e = exp_q.pop_front();
          check(e == osc_count, "R3 1 Hz tick pulse index", osc_count, e);
        end
      end
    end else if (tick_1hz) check(0, "R10 tick without oscillator pulse", 1, 0);
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] v);
    @(negedge clk); addr = a; wdata = v; wr_en = 1;
    @(negedge clk); wr_en = 0;
    if (a == A_CTRL) osc_count = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; #5; v = rdata;
  endtask

  task automatic run(input int n);
    repeat (n) begin @(negedge clk); osc_en = 1; end
    @(negedge clk); osc_en = 0;
  endtask

  task automatic pulse_evt(input bit alarm);
    @(negedge clk); if (alarm) alarm_evt = 1; else stopwatch_evt = 1;
    @(negedge clk); alarm_evt = 0; stopwatch_evt = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    rd(A_CTRL, d); check(d == 0, "R11 control after reset", d, 0);
    rd(A_STAT, d); check(d == 0, "R11 status after reset", d, 0);
    rd(A_MASK, d); check(d == 0, "R11 mask after reset", d, 0);
    check(!irq && !tick_1hz, "R11 outputs after reset", {irq, tick_1hz}, 0);

    // R1 readback
    wr(A_CTRL, 16'hFFFF); rd(A_CTRL, d); check(d == 16'h00E0, "R1 control readback", d, 16'h00E0);

    // R10 disabled block ignores oscillator
    wr(A_CTRL, 16'h0020); wr(A_STAT, 16'hFFFF);
    run(200); rd(A_STAT, d); check(d == 0, "R10 no ticks while disabled", d, 0);

    // 32768 Hz: R2, R4, R6, R9, R3
    wr(A_CTRL, 16'h0080); wr(A_STAT, 16'hFFFF); wr(A_MASK, 16'h0010);
    exp_q.push_back(32768);
    run(63); rd(A_STAT, d); check(d == 0, "R2 no base tick before pulse 64", d, 0);
    run(1);  rd(A_STAT, d); check(d == 16'h8000, "R2 R4 first base tick at 64", d, 16'h8000);
    wr(A_STAT, 16'hFFFF); rd(A_STAT, d); check(d == 0, "R6 clear all", d, 0);
    check(!irq, "R9 irq low before 1 Hz", irq, 0);
    run(32768 - 64);
    rd(A_STAT, d); check(d == 16'hFF90, "R4 all rates at 1 s wrap", d, 16'hFF90);
    check(irq, "R9 irq with masked 1 Hz bit", irq, 1);
    wr(A_STAT, 16'h0010); rd(A_STAT, d); check(d == 16'hFF80, "R6 partial clear", d, 16'hFF80);
    check(!irq, "R9 irq drops after clear", irq, 0);

    // 38400 Hz
    wr(A_CTRL, 16'h00C0); wr(A_STAT, 16'hFFFF);
    exp_q.push_back(38400);
    run(74); rd(A_STAT, d); check(d == 0, "R2 38400 no tick before 75", d, 0);
    run(1);  rd(A_STAT, d); check(d == 16'h8000, "R2 38400 first tick at 75", d, 16'h8000);
    run(38400 - 75);
    rd(A_STAT, d); check(d == 16'hFF90, "R4 38400 full wrap", d, 16'hFF90);

    // 32000 Hz
    wr(A_CTRL, 16'h00A0); wr(A_STAT, 16'hFFFF);
    exp_q.push_back(32000);
    run(63); rd(A_STAT, d); check(d == 16'h8000, "R2 32000 first tick at 63", d, 16'h8000);
    run(16000 - 64); rd(A_STAT, d); check(d[7] == 0, "R4 2 Hz not before 16000", d[7], 0);
    run(1); rd(A_STAT, d); check(d[7] == 1, "R4 2 Hz at pulse 16000", d[7], 1);

    // R1 select 3 acts as 32768
    wr(A_CTRL, 16'h00E0); wr(A_STAT, 16'hFFFF);
    exp_q.delete();
    run(63); rd(A_STAT, d); check(d == 0, "R1 select 3 no tick before 64", d, 0);
    run(1);  rd(A_STAT, d); check(d == 16'h8000, "R1 select 3 tick at 64", d, 16'h8000);

    // Events, mask, clear rules
    wr(A_CTRL, 16'h0000); wr(A_MASK, 16'h0000); wr(A_STAT, 16'hFFFF);
    pulse_evt(1);
    rd(A_STAT, d); check(d == 16'h0004, "R5 alarm sets bit 2", d, 16'h0004);
    check(!irq, "R9 masked alarm no irq", irq, 0);
    wr(A_MASK, 16'h0004); @(negedge clk); #5; check(irq, "R9 irq after mask set", irq, 1);
    wr(A_MASK, 16'hFFFF); rd(A_MASK, d); check(d == 16'hFF95, "R8 mask implemented bits", d, 16'hFF95);
    pulse_evt(0);
    rd(A_STAT, d); check(d == 16'h0005, "R5 stopwatch sets bit 0", d, 16'h0005);
    wr(A_STAT, 16'h0000); rd(A_STAT, d); check(d == 16'h0005, "R6 write zero keeps bits", d, 16'h0005);
    wr(A_STAT, 16'h0001); rd(A_STAT, d); check(d == 16'h0004, "R6 clear bit 0 only", d, 16'h0004);
    @(negedge clk); addr = A_STAT; wdata = 16'h0004; wr_en = 1; alarm_evt = 1;
    @(negedge clk); wr_en = 0; alarm_evt = 0;
    rd(A_STAT, d); check(d == 16'h0004, "R7 set wins over clear", d, 16'h0004);
    wr(A_STAT, 16'hFFFF); rd(A_STAT, d); check(d == 0, "R6 final clear", d, 0);
    check(!irq, "R9 irq low when empty", irq, 0);

    check(exp_q.size() == 0, "R3 all expected 1 Hz ticks seen", exp_q.size(), 0);
    finish_run();
  end
endmodule